// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Don't-Care Fields

This block watches a running clock's hour, minute and second bytes and decides, once per second, whether the programmed alarm time has been reached. It does not keep time itself. A separate counter supplies the current time bytes and pulses a one-cycle strobe each time those bytes advance. On that strobe the block compares all three fields against the alarm bytes. When every field agrees, it latches an alarm flag, emits a one-cycle pulse that reports the flag was newly set, and, if alarm interrupts are enabled, raises an interrupt request.

Any alarm byte with its two top bits both at 1 is a don't-care that matches every value of its field. Setting all three alarm bytes to don't-care therefore yields an alarm every second. Field bytes are read as packed BCD or as plain binary, depending on a mode input. Hours may be in 24-hour form, or in 12-hour form where bit 7 flags the afternoon. In 12-hour form both hour bytes are first normalised to a 0..23 value before they are compared. While the clock is frozen for setting, no comparison takes place. The flag stays set until the owner clears it with a one-cycle clear input.

Top module: `alarm_cmp`

## Requirements
- R1: An alarm byte whose bits 7 and 6 are both 1 matches any current value of its field. An alarm byte with only bit 7 set is not a don't-care.
- R2: With `bin_mode`=0 the field bytes are decoded as packed BCD: value = 10*bits[7:4] + bits[3:0]. For example, time 0x10 matches alarm 0x0A.
- R3: With `bin_mode`=1 the field bytes are compared as plain binary values. For example, time 0x10 does not match alarm 0x0A, and time 0x0A matches alarm 0x0A.
- R4: With `hr24`=0, each hour byte's bits [6:0] are decoded, taken modulo 12, and then increased by 12 if bit 7 is 1. So 0x12 (12 AM) equals hour 0 and 0x92 (12 PM) equals hour 12, and 0x01 differs from 0x81.
- R5: No comparison happens in a cycle without `tick`. Matching inputs without a strobe produce no pulse and no flag.
- R6: A match at a strobe sets `alm_flag` and drives `alm_new` high for exactly the one cycle after the strobe edge.
- R7: `irq` goes high only when the flag is newly set while `alm_ie`=1. Once high, it stays high until `flag_clr`.
- R8: If all three alarm bytes are don't-cares, every strobe produces a match.
- R9: A strobe that arrives while `freeze`=1 performs no comparison: no pulse, no flag change, no interrupt.
- R10: While the flag is set, further matches give no pulse and do not raise `irq`. `flag_clr` clears both `alm_flag` and `irq`. A new match in the same cycle as `flag_clr` wins, and the flag is set.
- R11: After reset, `alm_flag`, `alm_new` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe when the time bytes advance |
| freeze | input | 1 | Clock held for setting; blocks evaluation |
| bin_mode | input | 1 | 1: binary fields, 0: packed BCD |
| hr24 | input | 1 | 1: 24-hour format, 0: 12-hour with PM in bit 7 |
| alm_ie | input | 1 | Alarm interrupt enable |
| flag_clr | input | 1 | One-cycle clear of flag and interrupt |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| alm_flag | output | 1 | Latched alarm flag |
| alm_new | output | 1 | One-cycle pulse when the flag is newly set |
| irq | output | 1 | Alarm interrupt request |

## Verification
The block has no parameters. The field width is fixed at one byte by the don't-care code in its top two bits, so the bench builds the only variant there is. Because of that, every encoding corner can be reached directly:
- the BCD and binary readings of the same byte, where 0x10 against 0x0A matches in one mode and not the other;
- the twelve o'clock wrap in both halves of the day;
- a byte with only bit 7 set;
- a strobe and a clear landing in the same cycle.

// File: rtl/alarm_cmp.sv
module alarm_cmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       freeze,
  input  logic       bin_mode,
  input  logic       hr24,
  input  logic       alm_ie,
  input  logic       flag_clr,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  output logic       alm_flag,
  output logic       alm_new,
  output logic       irq
);

  function automatic logic [7:0] dec(input logic [7:0] b, input logic bin);
    dec = bin ? b : (8'(b[7:4]) * 8'd10 + 8'(b[3:0]));
  endfunction

  function automatic logic [7:0] dec_hour(input logic [7:0] b, input logic bin, input logic h24);
    logic [7:0] v;
    if (h24) begin
      dec_hour = dec(b, bin);
    end else begin
      v = dec({1'b0, b[6:0]}, bin) % 8'd12;
      dec_hour = b[7] ? v + 8'd12 : v;
    end
  endfunction

  logic wc_s, wc_m, wc_h, hit, eval, fresh;

  assign wc_s = &alm_sec[7:6];
  assign wc_m = &alm_min[7:6];
  assign wc_h = &alm_hour[7:6];

  assign hit = (wc_s || dec(alm_sec, bin_mode) == dec(cur_sec, bin_mode)) &&
               (wc_m || dec(alm_min, bin_mode) == dec(cur_min, bin_mode)) &&
               (wc_h || dec_hour(alm_hour, bin_mode, hr24) == dec_hour(cur_hour, bin_mode, hr24));

  assign eval  = tick && !freeze;
  assign fresh = eval && hit && !alm_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_flag <= 1'b0;
      alm_new  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      alm_new <= fresh;
      if (eval && hit)   alm_flag <= 1'b1;
      else if (flag_clr) alm_flag <= 1'b0;
      if (fresh && alm_ie) irq <= 1'b1;
      else if (flag_clr)   irq <= 1'b0;
    end
  end

  p_pulse_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alm_new |-> $past(tick) && !$past(freeze));
  p_frozen_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !alm_new);
  p_pulse_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alm_new |-> alm_flag);
  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(alm_ie) && alm_new);
  p_no_repeat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flag |=> !alm_new);
  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    alm_flag && !flag_clr |=> alm_flag);

endmodule

// File: tb/alarm_cmp_test.sv
module alarm_cmp_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, freeze = 0, bin_mode = 0, hr24 = 1, alm_ie = 0, flag_clr = 0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0;
  logic [7:0] alm_sec = 0, alm_min = 0, alm_hour = 0;
  logic alm_flag, alm_new, irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  alarm_cmp uut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] h, m, s);
    cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  task automatic set_alarm(input logic [7:0] h, m, s);
    alm_hour = h; alm_min = m; alm_sec = s;
  endtask

  task automatic strobe(input logic clr);
    @(negedge clk); tick = 1; flag_clr = clr;
    @(negedge clk); tick = 0; flag_clr = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic t_reset();
    chk("R11 flag", alm_flag, 0);
    chk("R11 pulse", alm_new, 0);
    chk("R11 irq", irq, 0);
  endtask

  task automatic t_bcd_match();
    bin_mode = 0; hr24 = 1; alm_ie = 0;
    set_time(8'h13, 8'h30, 8'h59); set_alarm(8'h13, 8'h30, 8'h59);
    strobe(0);
    chk("R6 pulse", alm_new, 1);
    chk("R6 flag", alm_flag, 1);
    chk("R7 irq off when disabled", irq, 0);
    @(negedge clk);
    chk("R6 pulse one cycle", alm_new, 0);
    strobe(0);
    chk("R10 no repeat pulse", alm_new, 0);
    clear_flag();
    chk("R10 clear", alm_flag, 0);
    set_alarm(8'h13, 8'h30, 8'h58);
    strobe(0);
    chk("R2 mismatch", alm_flag, 0);
  endtask

  task automatic t_modes();
    set_time(8'h01, 8'h02, 8'h10); set_alarm(8'h01, 8'h02, 8'h0A);
    bin_mode = 0; strobe(0);
    chk("R2 bcd 0x10==0x0A", alm_new, 1);
    clear_flag();
    bin_mode = 1; strobe(0);
    chk("R3 binary 0x10!=0x0A", alm_new, 0);
    cur_sec = 8'h0A; strobe(0);
    chk("R3 binary 0x0A match", alm_new, 1);
    clear_flag();
    bin_mode = 0;
  endtask

  task automatic t_wildcard();
    set_time(8'h07, 8'h44, 8'h23); set_alarm(8'h07, 8'h44, 8'hC5);
    strobe(0);
    chk("R1 sec dont-care", alm_new, 1);
    clear_flag();
    set_alarm(8'h07, 8'h80, 8'hC0);
    strobe(0);
    chk("R1 bit7 only not dont-care", alm_new, 0);
    set_alarm(8'hFF, 8'hC3, 8'hC0);
    for (int i = 0; i < 3; i++) begin
      cur_sec = 8'(i * 7);
      strobe(0);
      chk("R8 all dont-care fires", alm_new, 1);
      clear_flag();
    end
  endtask

  task automatic t_no_tick_freeze();
    set_time(8'h05, 8'h05, 8'h05); set_alarm(8'h05, 8'h05, 8'h05);
    repeat (4) @(negedge clk);
    chk("R5 no strobe no pulse", alm_new, 0);
    chk("R5 no strobe no flag", alm_flag, 0);
    freeze = 1; alm_ie = 1;
    strobe(0);
    chk("R9 frozen no pulse", alm_new, 0);
    chk("R9 frozen no flag", alm_flag, 0);
    chk("R9 frozen no irq", irq, 0);
    freeze = 0; alm_ie = 0;
  endtask

  task automatic t_irq();
    set_time(8'h05, 8'h05, 8'h05); set_alarm(8'h05, 8'h05, 8'h05);
    alm_ie = 1; strobe(0);
    chk("R7 irq raised", irq, 1);
    repeat (2) @(negedge clk);
    chk("R7 irq held", irq, 1);
    clear_flag();
    chk("R10 clr drops irq", irq, 0);
    alm_ie = 0; strobe(0);
    chk("R7 flag without irq", irq, 0);
    alm_ie = 1; strobe(0);
    chk("R10 no re-raise while flag set", irq, 0);
    clear_flag();
    alm_ie = 0;
    strobe(1);
    chk("R10 set wins over clear", alm_flag, 1);
    clear_flag();
  endtask

  task automatic t_12h();
    hr24 = 0; bin_mode = 0;
    set_time(8'h12, 8'h00, 8'h00); set_alarm(8'h92, 8'h00, 8'h00);
    strobe(0);
    chk("R4 12AM != 12PM", alm_new, 0);
    alm_hour = 8'h00; strobe(0);
    chk("R4 12AM == hour 0", alm_new, 1);
    clear_flag();
    set_time(8'h01, 8'h00, 8'h00); set_alarm(8'h81, 8'h00, 8'h00);
    strobe(0);
    chk("R4 1AM != 1PM", alm_new, 0);
    cur_hour = 8'h81; strobe(0);
    chk("R4 1PM match", alm_new, 1);
    clear_flag();
    hr24 = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_bcd_match();
    t_modes();
    t_wildcard();
    t_no_tick_freeze();
    t_irq();
    t_12h();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule